// File: doc/BRIEF.md
# Lazy Condition-Code Flag Evaluator

This unit turns the saved operands of an already executed operation into updated condition-code bits. A core that postpones its flag computation keeps the source, destination and result of the last flag-setting operation. It also keeps the operand size, the operation class and, for multiplies, the high product word. When the flags are needed, it presents those values to this block together with the current status word. One cycle later the block returns the new status word. The ALU datapath is not part of this block.

Carry and overflow come only from the top bits of the two operands and of the result, taken at the selected size. Subtraction and compare use the same rule with the source inverted, and the carry is inverted afterwards. A multiply-carry class writes its carry into a separate R flag. Move, logic and shift operations give only N and Z. The two multiply classes look at the full double-width product. A bit-test class has its own flag rule. A "flags live" class passes the status word through unchanged.

Each update is merged into the status word under a per-instruction update mask. The X bit is always cleared as part of that merge. Under extended arithmetic the old Z is kept whenever the new Z would be set, so a chain of extended operations can clear Z but never set it.

Top module: `cc_flag_eval`

## Requirements
- R1: While rst_ni is low and until the first accepted operation, valid_o is 0 and ccs_o is 0.
- R2: An operation presented with valid_i=1 appears on ccs_o and valid_o=1 exactly one clock later. When valid_i=0, valid_o falls to 0 and ccs_o holds its value.
- R3: Operation codes on op_i are: 0 add, 1 subtract/compare, 2 bit test, 3 multiply-carry, 4 move/logic/shift, 5 signed multiply, 6 unsigned multiply, 7 flags live. Status bit positions are C=0, V=1, Z=2, N=3, X=4 and R=8. For add, let s, d and r be the top bits of src_i, dst_i and res_i at the selected size. If r=1, then N=1, V=!s&!d and C=s&d. If r=0, then Z=1 when res_i at size is zero, V=s&d and C=s|d.
- R4: For subtract, s is inverted before the add rule is applied, and C is inverted after it.
- R5: Multiply-carry applies the add rule but places the carry value in R. C is then produced as 0.
- R6: Move/logic/shift produces N = top bit of res_i at size, Z = (result zero at size and N=0), and V=C=0.
- R7: Signed multiply forms the product {mul_hi_i,res_i}. Z=1 when the product is zero and N = product bit 63. V=1 unless mul_hi_i equals the sign extension of res_i.
- R8: Unsigned multiply: Z and N as in R7, and V=1 whenever mul_hi_i is nonzero.
- R9: For classes 0, 1, 3, 4, 5 and 6, the effective mask is upd_mask_i OR the X bit. Bits in the effective mask take the new flag value (0 for X and for unproduced flags). All other bits keep their ccs_i value.
- R10: When x_i=1 and the new Z is 1, Z is removed from the effective mask, so Z keeps its ccs_i value.
- R11: Bit test selects bit number src_i[4:0] of dst_i. N is set to that bit. Z=1 when that bit and all lower bits of dst_i are zero. X is cleared. All other bits keep ccs_i, and upd_mask_i and x_i have no effect.
- R12: Bit test with legacy_i=1 also clears V and C.
- R13: Flags live (code 7) returns ccs_i unchanged.
- R14: size_i encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Operand bits above the selected size do not affect any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation class code |
| size_i | input | 2 | Operand size code |
| src_i | input | DW | Saved source operand (bit number for bit test) |
| dst_i | input | DW | Saved destination operand (tested value for bit test) |
| res_i | input | DW | Saved result (low product word for multiplies) |
| mul_hi_i | input | DW | High product word |
| x_i | input | 1 | Extended-arithmetic state |
| legacy_i | input | 1 | Older core revision: bit test also clears V and C |
| upd_mask_i | input | CCS_W | Per-instruction flag-update mask |
| ccs_i | input | CCS_W | Current status word |
| valid_o | output | 1 | ccs_o holds a new result |
| ccs_o | output | CCS_W | Updated status word |

## Verification
The hardest case to reach is the interaction of the effective mask with the extended-arithmetic Z rule. The old Z must survive only when x_i is set and the new Z is 1. The stimulus covers this by sweeping many unrelated mask and status patterns, with x_i alternating, against results that are zero and results that are negative. The size rule is checked by setting operand bits above the selected size to junk, so that any leak from those bits shows up as a wrong flag.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_BTST = 3'd2,
    OP_MCP  = 3'd3,
    OP_MOVE = 3'd4,
    OP_MULS = 3'd5,
    OP_MULU = 3'd6,
    OP_LIVE = 3'd7
  } cc_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORDX = 2'd3
  } cc_size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic r;
  } cc_flags_t;
endpackage

// File: rtl/cc_size_view.sv
module cc_size_view #(
  parameter int DW = 32
) (
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] val_i,
  output logic          msb_o,
  output logic          zero_o
);
  always_comb begin
    unique case (size_i)
      2'd0: begin
        msb_o  = val_i[7];
        zero_o = (val_i[7:0] == 8'd0);
      end
      2'd1: begin
        msb_o  = val_i[15];
        zero_o = (val_i[15:0] == 16'd0);
      end
      default: begin
        msb_o  = val_i[DW-1];
        zero_o = (val_i == '0);
      end
    endcase
  end
endmodule

// File: rtl/cc_arith_flags.sv
module cc_arith_flags
  import cc_pkg::*;
(
  input  logic      s_msb_i,
  input  logic      d_msb_i,
  input  logic      r_msb_i,
  input  logic      r_zero_i,
  input  logic      sub_i,
  output cc_flags_t flags_o
);
  logic s, cy;

  always_comb begin
    s       = s_msb_i ^ sub_i;
    flags_o = '0;
    if (r_msb_i) begin
      flags_o.n = 1'b1;
      flags_o.v = ~s & ~d_msb_i;
      cy        = s & d_msb_i;
    end else begin
      flags_o.z = r_zero_i;
      flags_o.v = s & d_msb_i;
      cy        = s | d_msb_i;
    end
    flags_o.c = cy ^ sub_i;
  end
endmodule

// File: rtl/cc_mul_flags.sv
module cc_mul_flags
  import cc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic          signed_i,
  output cc_flags_t     flags_o
);
  logic prod_zero;

  always_comb begin
    prod_zero = (lo_i == '0) && (hi_i == '0);
    flags_o   = '0;
    flags_o.z = prod_zero;
    flags_o.n = ~prod_zero & hi_i[DW-1];
    if (signed_i) flags_o.v = (hi_i != {DW{lo_i[DW-1]}});
    else          flags_o.v = (hi_i != '0);
  end
endmodule

// File: rtl/cc_btst.sv
module cc_btst #(
  parameter int DW    = 32,
  parameter int CCS_W = 16,
  parameter int C_POS = 0,
  parameter int V_POS = 1,
  parameter int Z_POS = 2,
  parameter int N_POS = 3,
  parameter int X_POS = 4
) (
  input  logic [DW-1:0]    val_i,
  input  logic [DW-1:0]    sel_i,
  input  logic             legacy_i,
  input  logic [CCS_W-1:0] ccs_i,
  output logic [CCS_W-1:0] ccs_o
);
  localparam int BN_W = $clog2(DW);

  logic [BN_W-1:0] bit_num;
  logic [DW-1:0]   low_mask;
  logic            bset, fz;

  assign bit_num = sel_i[BN_W-1:0];

  for (genvar i = 0; i < DW; i++) begin : g_low
    assign low_mask[i] = (BN_W'(i) <= bit_num);
  end

  assign bset = val_i[bit_num];
  assign fz   = ((val_i & low_mask) == '0);

  always_comb begin
    ccs_o = ccs_i;
    ccs_o[X_POS] = 1'b0;
    if (legacy_i) begin
      ccs_o[V_POS] = 1'b0;
      ccs_o[C_POS] = 1'b0;
    end
    ccs_o[N_POS] = bset;
    ccs_o[Z_POS] = fz;
  end
endmodule

// File: rtl/cc_writeback.sv
module cc_writeback
  import cc_pkg::*;
#(
  parameter int CCS_W = 16,
  parameter int C_POS = 0,
  parameter int V_POS = 1,
  parameter int Z_POS = 2,
  parameter int N_POS = 3,
  parameter int X_POS = 4,
  parameter int R_POS = 8
) (
  input  cc_flags_t        flags_i,
  input  logic             x_i,
  input  logic [CCS_W-1:0] upd_mask_i,
  input  logic [CCS_W-1:0] ccs_i,
  output logic [CCS_W-1:0] ccs_o
);
  logic [CCS_W-1:0] new_v, eff_mask;

  always_comb begin
    new_v        = '0;
    new_v[C_POS] = flags_i.c;
    new_v[V_POS] = flags_i.v;
    new_v[Z_POS] = flags_i.z;
    new_v[N_POS] = flags_i.n;
    new_v[R_POS] = flags_i.r;

    eff_mask        = upd_mask_i;
    eff_mask[X_POS] = 1'b1;
    // extended chain: a set Z never overrides the old one
    if (x_i && flags_i.z) eff_mask[Z_POS] = 1'b0;

    ccs_o = (ccs_i & ~eff_mask) | (new_v & eff_mask);
  end
endmodule

// File: rtl/cc_flag_eval.sv
module cc_flag_eval
  import cc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CCS_W = 16,
  parameter int C_POS = 0,
  parameter int V_POS = 1,
  parameter int Z_POS = 2,
  parameter int N_POS = 3,
  parameter int X_POS = 4,
  parameter int R_POS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    src_i,
  input  logic [DW-1:0]    dst_i,
  input  logic [DW-1:0]    res_i,
  input  logic [DW-1:0]    mul_hi_i,
  input  logic             x_i,
  input  logic             legacy_i,
  input  logic [CCS_W-1:0] upd_mask_i,
  input  logic [CCS_W-1:0] ccs_i,
  output logic             valid_o,
  output logic [CCS_W-1:0] ccs_o
);
  cc_op_e           op;
  logic             s_msb, d_msb, r_msb, s_zero, d_zero, r_zero;
  cc_flags_t        arith_f, mul_f, sel_f;
  logic [CCS_W-1:0] wb_ccs, bt_ccs, ccs_nxt;

  assign op = cc_op_e'(op_i);

  cc_size_view #(.DW(DW)) i_src_view (
    .size_i(size_i), .val_i(src_i), .msb_o(s_msb), .zero_o(s_zero)
  );
  cc_size_view #(.DW(DW)) i_dst_view (
    .size_i(size_i), .val_i(dst_i), .msb_o(d_msb), .zero_o(d_zero)
  );
  cc_size_view #(.DW(DW)) i_res_view (
    .size_i(size_i), .val_i(res_i), .msb_o(r_msb), .zero_o(r_zero)
  );

  cc_arith_flags i_arith (
    .s_msb_i (s_msb),
    .d_msb_i (d_msb),
    .r_msb_i (r_msb),
    .r_zero_i(r_zero),
    .sub_i   (op == OP_SUB),
    .flags_o (arith_f)
  );

  cc_mul_flags #(.DW(DW)) i_mul (
    .lo_i    (res_i),
    .hi_i    (mul_hi_i),
    .signed_i(op == OP_MULS),
    .flags_o (mul_f)
  );

  cc_btst #(
    .DW(DW), .CCS_W(CCS_W), .C_POS(C_POS), .V_POS(V_POS),
    .Z_POS(Z_POS), .N_POS(N_POS), .X_POS(X_POS)
  ) i_btst (
    .val_i   (dst_i),
    .sel_i   (src_i),
    .legacy_i(legacy_i),
    .ccs_i   (ccs_i),
    .ccs_o   (bt_ccs)
  );

  always_comb begin
    sel_f = '0;
    unique case (op)
      OP_ADD, OP_SUB: sel_f = arith_f;
      OP_MCP: begin
        sel_f   = arith_f;
        sel_f.r = arith_f.c;
        sel_f.c = 1'b0;
      end
      OP_MOVE: begin
        sel_f.n = r_msb;
        sel_f.z = ~r_msb & r_zero;
      end
      OP_MULS, OP_MULU: sel_f = mul_f;
      default: sel_f = '0;
    endcase
  end

  cc_writeback #(
    .CCS_W(CCS_W), .C_POS(C_POS), .V_POS(V_POS), .Z_POS(Z_POS),
    .N_POS(N_POS), .X_POS(X_POS), .R_POS(R_POS)
  ) i_wb (
    .flags_i   (sel_f),
    .x_i       (x_i),
    .upd_mask_i(upd_mask_i),
    .ccs_i     (ccs_i),
    .ccs_o     (wb_ccs)
  );

  always_comb begin
    unique case (op)
      OP_BTST: ccs_nxt = bt_ccs;
      OP_LIVE: ccs_nxt = ccs_i;
      default: ccs_nxt = wb_ccs;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ccs_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) ccs_o <= ccs_nxt;
    end
  end
endmodule

// File: rtl/cc_flag_eval_chk.sv
module cc_flag_eval_chk #(
  parameter int DW    = 32,
  parameter int CCS_W = 16,
  parameter int C_POS = 0,
  parameter int V_POS = 1,
  parameter int Z_POS = 2,
  parameter int N_POS = 3,
  parameter int X_POS = 4,
  parameter int R_POS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic             x_i,
  input logic [CCS_W-1:0] upd_mask_i,
  input logic [CCS_W-1:0] ccs_i,
  input logic             valid_o,
  input logic [CCS_W-1:0] ccs_o
);
  localparam logic [2:0] OPC_BTST = 3'd2;
  localparam logic [2:0] OPC_MOVE = 3'd4;
  localparam logic [2:0] OPC_LIVE = 3'd7;
  localparam logic [CCS_W-1:0] X_M  = CCS_W'(1) << X_POS;
  localparam logic [CCS_W-1:0] BT_M = (CCS_W'(1) << X_POS) | (CCS_W'(1) << N_POS) |
                                      (CCS_W'(1) << Z_POS) | (CCS_W'(1) << V_POS) |
                                      (CCS_W'(1) << C_POS);

  logic wb_cls;
  assign wb_cls = (op_i != OPC_BTST) && (op_i != OPC_LIVE);

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ccs_o));

  // R13
  live_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OPC_LIVE) |=> ccs_o == $past(ccs_i));

  // R9
  x_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wb_cls) |=> !ccs_o[X_POS]);

  // R9
  unmasked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wb_cls) |=> ((ccs_o ^ $past(ccs_i)) & ~($past(upd_mask_i) | X_M)) == '0);

  // R10
  ext_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wb_cls && x_i && !ccs_i[Z_POS]) |=> !ccs_o[Z_POS]);

  // R11
  btst_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OPC_BTST) |=> (((ccs_o ^ $past(ccs_i)) & ~BT_M) == '0) && !ccs_o[X_POS]);

  // R6
  move_no_v_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OPC_MOVE) |=> (!ccs_o[V_POS] || $past(ccs_i[V_POS])));
endmodule

bind cc_flag_eval cc_flag_eval_chk #(
  .DW(DW), .CCS_W(CCS_W), .C_POS(C_POS), .V_POS(V_POS), .Z_POS(Z_POS),
  .N_POS(N_POS), .X_POS(X_POS), .R_POS(R_POS)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .x_i       (x_i),
  .upd_mask_i(upd_mask_i),
  .ccs_i     (ccs_i),
  .valid_o   (valid_o),
  .ccs_o     (ccs_o)
);

// File: tb/test_cc_flag_eval.sv
module test_cc_flag_eval;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] src_i = '0, dst_i = '0, res_i = '0, mul_hi_i = '0;
  logic        x_i = 1'b0, legacy_i = 1'b0;
  logic [15:0] upd_mask_i = '0, ccs_i = '0;
  logic        valid_o;
  logic [15:0] ccs_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  cc_flag_eval i_cc_flag_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .size_i(size_i), .src_i(src_i), .dst_i(dst_i), .res_i(res_i),
    .mul_hi_i(mul_hi_i), .x_i(x_i), .legacy_i(legacy_i),
    .upd_mask_i(upd_mask_i), .ccs_i(ccs_i), .valid_o(valid_o), .ccs_o(ccs_o)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] model(
    logic [2:0] op, logic [1:0] sz, logic [31:0] src, logic [31:0] dst,
    logic [31:0] res, logic [31:0] hi, logic x, logic leg,
    logic [15:0] mask, logic [15:0] ccs);
    int w;
    logic [31:0] sm;
    logic [63:0] p;
    logic s, d, r, rz, n, z, v, c, rr, cy;
    logic [15:0] nv, em, o;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    sm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    s = src[w-1]; d = dst[w-1]; r = res[w-1];
    rz = ((res & sm) == 32'd0);
    n = 0; z = 0; v = 0; c = 0; rr = 0;
    case (op)
      3'd7: return ccs;
      3'd2: begin
        o = ccs & ~16'h001C;
        if (leg) o = o & ~16'h0003;
        o[3] = dst[src[4:0]];
        o[2] = ((dst << (5'd31 - src[4:0])) == 32'd0);
        return o;
      end
      3'd0, 3'd1, 3'd3: begin
        if (op == 3'd1) s = ~s;
        if (r) begin n = 1; v = ~s & ~d; cy = s & d; end
        else begin z = rz; v = s & d; cy = s | d; end
        if (op == 3'd1) cy = ~cy;
        if (op == 3'd3) rr = cy; else c = cy;
      end
      3'd4: begin n = r; z = ~r & rz; end
      default: begin
        p = {hi, res};
        z = (p == 64'd0);
        n = p[63];
        if (op == 3'd5) v = (p != {{32{res[31]}}, res});
        else            v = (hi != 32'd0);
      end
    endcase
    nv = {7'd0, rr, 4'd0, n, z, v, c};
    em = mask | 16'h0010;
    if (x && z) em[2] = 1'b0;
    return (ccs & ~em) | (nv & em);
  endfunction

  task automatic run(string tag, logic [2:0] op, logic [1:0] sz, logic [31:0] src,
                     logic [31:0] dst, logic [31:0] res, logic [31:0] hi,
                     logic x, logic leg, logic [15:0] mask, logic [15:0] ccs);
    @(negedge clk_i);
    valid_i = 1; op_i = op; size_i = sz; src_i = src; dst_i = dst; res_i = res;
    mul_hi_i = hi; x_i = x; legacy_i = leg; upd_mask_i = mask; ccs_i = ccs;
    @(negedge clk_i);
    check(tag, {16'd0, ccs_o}, {16'd0, model(op, sz, src, dst, res, hi, x, leg, mask, ccs)});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] last;
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", {31'd0, valid_o}, 32'd0);
    check("R1 ccs in reset", {16'd0, ccs_o}, 32'd0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    check("R1 ccs after reset", {16'd0, ccs_o}, 32'd0);

    // add / subtract / multiply-carry over signs, result class and size (R3 R4 R5 R14)
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      for (int sz = 0; sz < 4; sz++) begin
        for (int sv = 0; sv < 2; sv++) begin
          for (int dv = 0; dv < 2; dv++) begin
            for (int rc = 0; rc < 3; rc++) begin
              int w;
              logic [31:0] sm, junk, top, sv32, dv32, rv32;
              string tag;
              w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
              sm   = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
              junk = ~sm & 32'hC3C3_C300;
              top  = 32'd1 << (w - 1);
              sv32 = (sv != 0 ? top : 32'd1) | junk;
              dv32 = (dv != 0 ? top : 32'd0) | junk;
              rv32 = ((rc == 0) ? top : (rc == 1) ? 32'd0 : 32'd2) | junk;
              tag  = (op == 0) ? "R3" : (op == 1) ? "R4" : "R5";
              if (sz < 2) tag = {tag, " R14"};
              run(tag, 3'(op), 2'(sz), sv32, dv32, rv32, 32'd0, 1'b0, 1'b0,
                  16'h010F, 16'hA5A5 ^ 16'(sz * 3 + rc));
            end
          end
        end
      end
    end

    // move class (R6)
    for (int sz = 0; sz < 4; sz++) begin
      for (int rc = 0; rc < 3; rc++) begin
        int w;
        logic [31:0] junk, rv32;
        w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        junk = (w == 32) ? 32'd0 : (32'hFFFF_FF00 << (w - 8));
        rv32 = ((rc == 0) ? (32'd1 << (w - 1)) : (rc == 1) ? 32'd0 : 32'd4) | junk;
        run("R6", 3'd4, 2'(sz), 32'hFFFF_FFFF, 32'hFFFF_FFFF, rv32, 32'd0, 1'b0, 1'b0,
            16'h000F, 16'hFFFF);
      end
    end

    // multiplies (R7 R8)
    for (int k = 0; k < 8; k++) begin
      logic [31:0] hi, lo;
      case (k)
        0: begin hi = 32'h0;          lo = 32'h0;          end
        1: begin hi = 32'h0;          lo = 32'h1;          end
        2: begin hi = 32'h0;          lo = 32'h8000_0000;  end
        3: begin hi = 32'hFFFF_FFFF;  lo = 32'h8000_0000;  end
        4: begin hi = 32'hFFFF_FFFF;  lo = 32'h1;          end
        5: begin hi = 32'h1;          lo = 32'h0;          end
        6: begin hi = 32'h8000_0000;  lo = 32'h0;          end
        default: begin hi = 32'h7FFF_FFFF; lo = 32'hFFFF_FFFF; end
      endcase
      run("R7", 3'd5, 2'd2, 32'd0, 32'd0, lo, hi, 1'b0, 1'b0, 16'h000F, 16'h00F0);
      run("R8", 3'd6, 2'd2, 32'd0, 32'd0, lo, hi, 1'b0, 1'b0, 16'h000F, 16'h00F0);
    end

    // bit test over every bit number (R11 R12)
    for (int b = 0; b < 32; b++) begin
      for (int lg = 0; lg < 2; lg++) begin
        logic [31:0] sel;
        string tag;
        sel = 32'(b) | 32'hFFFF_FFE0;
        tag = (lg != 0) ? "R12" : "R11";
        run(tag, 3'd2, 2'd2, sel, 32'd1 << b, 32'd0, 32'd0, 1'b1, 1'(lg), 16'hFFFF, 16'hFFFF);
        run(tag, 3'd2, 2'd2, sel, (b < 31) ? (32'd2 << b) : 32'd0, 32'd0, 32'd0, 1'b0, 1'(lg),
            16'h0000, 16'h5A5F);
        if (b > 0) run(tag, 3'd2, 2'd2, sel, 32'd1, 32'd0, 32'd0, 1'b0, 1'(lg), 16'h0000, 16'h0000);
      end
    end

    // writeback mask and extended Z (R9 R10)
    for (int i = 0; i < 48; i++) begin
      logic [15:0] m, cc;
      logic        xv;
      string tag;
      m  = 16'(i * 16'h2F1B) ^ 16'h5A3C;
      cc = 16'(i * 16'h9E37) ^ 16'h0014;
      xv = i[0];
      tag = xv ? "R10" : "R9";
      run(tag, 3'd0, 2'd2, 32'd0, 32'd0, 32'd0, 32'd0, xv, 1'b0, m, cc);
      run(tag, 3'd1, 2'd2, 32'd5, 32'd5, 32'h8000_0000, 32'd0, xv, 1'b0, m, cc | 16'h0004);
    end

    // flags live (R13)
    for (int i = 0; i < 8; i++)
      run("R13", 3'd7, 2'(i), 32'd0, 32'd0, 32'd0, 32'd1, 1'(i), 1'b1, 16'hFFFF, 16'(i * 16'h3141));

    check("R2 valid high", {31'd0, valid_o}, 32'd1);
    last = ccs_o;
    @(negedge clk_i);
    valid_i = 0; ccs_i = ~ccs_i; op_i = 3'd7;
    repeat (2) @(negedge clk_i);
    check("R2 valid low", {31'd0, valid_o}, 32'd0);
    check("R2 hold", {16'd0, ccs_o}, {16'd0, last});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule